// File: doc/BRIEF.md
# Banked Flash Operation Arbiter

This block sits in front of a multi-bank flash array and decides, one command per cycle, what the array may do next. It accepts program, erase, suspend, resume, read-permission and clear-status commands, each with a word address. It remembers which word is being programmed and which block is being erased, and it models how long each operation takes with a cycle counter per operation kind. Results come back through a five-bit status word and a registered read-permission answer.

Only one bank may be writing at any time. Reads to the other banks continue while a bank is writing. An erase can be paused so that the host can program or read elsewhere, with only the erasing block fenced off. A program can be paused so that the host can read anywhere except the single word in flight. Each bank covers 2^20 words. The bank that holds the small blocks is chosen by a configuration pin: the highest bank or the lowest. Inside that bank the small blocks sit at the same end of the bank.

Top module: `flash_op_arbiter`

## Requirements
- R1: After reset the status word is 5'b00001 and no read answer is valid. Opcodes: 0 none, 1 read check, 2 program, 3 erase, 4 suspend, 5 resume, 6 clear status. Status bits: bit0 ready, bit1 program error, bit2 erase error, bit3 program suspended, bit4 erase suspended.
- R2: A program accepted at clock edge k drops ready at edge k and raises it again at edge k+PROG_CYCLES.
- R3: An erase accepted at edge k drops ready at edge k and raises it again at edge k+ERASE_CYCLES.
- R4: While a program or erase is running, any further program sets bit1 and any erase sets bit2, in any bank. The running operation's finishing edge does not move.
- R5: A read check issued at edge k is answered at edge k (rd_valid_o high for that cycle). While an operation runs, reads to its bank are refused (rd_ok_o low) and reads to every other bank are allowed.
- R6: A suspend during a running erase sets bit4 and ready. While the erase is suspended, reads inside the erasing block are refused and reads elsewhere are allowed.
- R7: While an erase is suspended, a program to another block (same bank included) is accepted. A program inside the erasing block is refused with bit1. Suspend and resume are ignored while that program runs. When it finishes, bit4 stays set.
- R8: A suspend during a running program sets bit3 and ready. While the program is suspended, only the word being programmed is refused for reads.
- R9: The remaining cycle count freezes while suspended. An operation accepted at edge k, suspended at edge s and resumed at edge r finishes at edge k+N+(r-s).
- R10: In the idle state a suspend or a resume leaves the status word unchanged.
- R11: Bits 1 and 2 stay set until a clear-status command, which resets both.
- R12: Bank index is address bits [23:20]. param_top=1 puts the small-block bank at bank 15 with its four 16K-word blocks in bank offsets 0xF0000-0xFFFFF. param_top=0 puts them in bank 0 at offsets 0x00000-0x0FFFF. All other blocks span 64K words. Block identity for the erase fence follows this layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| param_top | input | 1 | 1: small-block bank at the top of the address space; 0: at the bottom |
| cmd_op | input | 3 | Command opcode, 0 when idle |
| cmd_addr | input | 24 | Word address of the command |
| rd_valid_o | output | 1 | A read-permission answer is present this cycle |
| rd_ok_o | output | 1 | The read in question may proceed |
| status_o | output | 5 | Ready, program error, erase error, program suspended, erase suspended |

## Verification
Every result is registered once. A command sampled at edge k shows up in the status word and the read answer right after edge k. An operation accepted at edge k finishes at edge k+N, and a suspend/resume pair moves that edge by (r-s). The bench drives on falling edges and reads at the falling edge after each command. It keeps its own edge counter, and the finishing edge it observes is compared with the arithmetic prediction rather than with a timeout. The read-permission sweeps issue one read per granule across whole banks for both settings of the configuration pin. Each answer is compared with a block boundary that the bench computes from the address alone.

// File: rtl/fa_pkg.sv
package fa_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_READ   = 3'd1,
        OP_PROG   = 3'd2,
        OP_ERASE  = 3'd3,
        OP_SUSP   = 3'd4,
        OP_RESUME = 3'd5,
        OP_CLR    = 3'd6
    } fa_op_e;

    localparam int ST_READY = 0;
    localparam int ST_PERR  = 1;
    localparam int ST_EERR  = 2;
    localparam int ST_PSUS  = 3;
    localparam int ST_ESUS  = 4;
    localparam int ST_W     = 5;
endpackage

// File: rtl/fa_addr_decode.sv
module fa_addr_decode #(
    parameter int ADDR_W      = 24,
    parameter int BANK_W      = 4,
    parameter int MAIN_OFS_W  = 16,
    parameter int PARAM_OFS_W = 14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              param_top,
    output logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] blk_key
);
    localparam int SEL_W = ADDR_W - BANK_W - MAIN_OFS_W;
    localparam logic [ADDR_W-1:0] MAIN_MASK  = {{(ADDR_W-MAIN_OFS_W){1'b1}}, {MAIN_OFS_W{1'b0}}};
    localparam logic [ADDR_W-1:0] SMALL_MASK = {{(ADDR_W-PARAM_OFS_W){1'b1}}, {PARAM_OFS_W{1'b0}}};

    logic [SEL_W-1:0] sel;
    logic             small_blk;

    always_comb begin
        bank      = addr[ADDR_W-1 -: BANK_W];
        sel       = addr[MAIN_OFS_W +: SEL_W];
        small_blk = (bank == (param_top ? {BANK_W{1'b1}} : {BANK_W{1'b0}}))
                 && (sel  == (param_top ? {SEL_W{1'b1}}  : {SEL_W{1'b0}}));
        blk_key   = addr & (small_blk ? SMALL_MASK : MAIN_MASK);
    end
endmodule

// File: rtl/fa_op_counter.sv
module fa_op_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        done  = run && (cnt_q == CNT_W'(1));
        count = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/flash_op_arbiter.sv
module flash_op_arbiter
    import fa_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int BANK_W       = 4,
    parameter int MAIN_OFS_W   = 16,
    parameter int PARAM_OFS_W  = 14,
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              param_top,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              rd_valid_o,
    output logic              rd_ok_o,
    output logic [ST_W-1:0]   status_o
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int SLOTS   = 2;

    typedef struct packed {
        logic              p_busy;
        logic              p_susp;
        logic              e_busy;
        logic              e_susp;
        logic              p_err;
        logic              e_err;
        logic              rd_valid;
        logic              rd_ok;
        logic [ADDR_W-1:0] p_addr;
        logic [ADDR_W-1:0] e_key;
    } arb_state_t;

    arb_state_t state_d, state_q;

    logic [BANK_W-1:0] cmd_bank;
    logic [ADDR_W-1:0] cmd_key;

    logic [SLOTS-1:0] load_w, run_w, done_w;
    logic [CNT_W-1:0] cnt_w [SLOTS];

    logic              prog_busy_w, prog_susp_w, erase_susp_w;
    logic [CNT_W-1:0]  prog_cnt_w, erase_cnt_w;

    fa_addr_decode #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W),
        .MAIN_OFS_W(MAIN_OFS_W), .PARAM_OFS_W(PARAM_OFS_W)
    ) dec_i (
        .addr(cmd_addr), .param_top(param_top),
        .bank(cmd_bank), .blk_key(cmd_key)
    );

    // slot 0: program timer, slot 1: erase timer
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        localparam int LOAD_CYC = (g == 0) ? PROG_CYCLES : ERASE_CYCLES;
        fa_op_counter #(.CNT_W(CNT_W)) cnt_i (
            .clk(clk), .rst_n(rst_n),
            .load(load_w[g]), .load_val(CNT_W'(LOAD_CYC)),
            .run(run_w[g]), .done(done_w[g]), .count(cnt_w[g])
        );
    end

    always_comb begin
        run_w[0] = state_q.p_busy && !state_q.p_susp;
        run_w[1] = state_q.e_busy && !state_q.e_susp;
    end

    always_comb begin
        state_d          = state_q;
        state_d.rd_valid = 1'b0;
        state_d.rd_ok    = 1'b0;
        load_w           = '0;

        // operations that end on this edge are retired before the command is judged
        if (done_w[0]) state_d.p_busy = 1'b0;
        if (done_w[1]) state_d.e_busy = 1'b0;

        case (fa_op_e'(cmd_op))
            OP_READ: begin
                state_d.rd_valid = 1'b1;
                state_d.rd_ok =
                    !(state_d.p_busy && !state_d.p_susp &&
                      cmd_bank == state_d.p_addr[ADDR_W-1 -: BANK_W]) &&
                    !(state_d.e_busy && !state_d.e_susp &&
                      cmd_bank == state_d.e_key[ADDR_W-1 -: BANK_W]) &&
                    !(state_d.e_busy && state_d.e_susp && cmd_key == state_d.e_key) &&
                    !(state_d.p_busy && state_d.p_susp && cmd_addr == state_d.p_addr);
            end
            OP_PROG: begin
                if (!state_d.p_busy &&
                    (!state_d.e_busy || (state_d.e_susp && cmd_key != state_d.e_key))) begin
                    state_d.p_busy = 1'b1;
                    state_d.p_addr = cmd_addr;
                    load_w[0]      = 1'b1;
                end else begin
                    state_d.p_err  = 1'b1;
                end
            end
            OP_ERASE: begin
                if (!state_d.p_busy && !state_d.e_busy) begin
                    state_d.e_busy = 1'b1;
                    state_d.e_key  = cmd_key;
                    load_w[1]      = 1'b1;
                end else begin
                    state_d.e_err  = 1'b1;
                end
            end
            OP_SUSP: begin
                if (state_d.p_busy && !state_d.p_susp && !state_d.e_busy) begin
                    state_d.p_susp = 1'b1;
                end else if (state_d.e_busy && !state_d.e_susp && !state_d.p_busy) begin
                    state_d.e_susp = 1'b1;
                end
            end
            OP_RESUME: begin
                if (state_d.p_susp) begin
                    state_d.p_susp = 1'b0;
                end else if (state_d.e_susp && !state_d.p_busy) begin
                    state_d.e_susp = 1'b0;
                end
            end
            OP_CLR: begin
                state_d.p_err = 1'b0;
                state_d.e_err = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        rd_valid_o         = state_q.rd_valid;
        rd_ok_o            = state_q.rd_ok;
        status_o[ST_READY] = !((state_q.p_busy && !state_q.p_susp) ||
                               (state_q.e_busy && !state_q.e_susp));
        status_o[ST_PERR]  = state_q.p_err;
        status_o[ST_EERR]  = state_q.e_err;
        status_o[ST_PSUS]  = state_q.p_susp;
        status_o[ST_ESUS]  = state_q.e_susp;
        prog_busy_w        = state_q.p_busy;
        prog_susp_w        = state_q.p_susp;
        erase_susp_w       = state_q.e_susp;
        prog_cnt_w         = cnt_w[0];
        erase_cnt_w        = cnt_w[1];
    end
endmodule

// File: rtl/fa_arbiter_chk.sv
module fa_arbiter_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cmd_op,
    input logic [4:0]       status_o,
    input logic             rd_valid_o,
    input logic             prog_busy_w,
    input logic             prog_susp_w,
    input logic             erase_susp_w,
    input logic [CNT_W-1:0] prog_cnt_w,
    input logic [CNT_W-1:0] erase_cnt_w
);
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[1] && cmd_op != 3'd6) |=> status_o[1]);

    assert_rd_answer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd1) |=> rd_valid_o);

    assert_rd_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op != 3'd1) |=> !rd_valid_o);

    assert_prog_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_susp_w |=> $stable(prog_cnt_w));

    assert_erase_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_susp_w |=> $stable(erase_cnt_w));

    assert_susp_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[4] && !prog_busy_w) |-> status_o[0]);

    assert_single_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_o[3] && status_o[4]));
endmodule

bind flash_op_arbiter fa_arbiter_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .status_o(status_o),
    .rd_valid_o(rd_valid_o), .prog_busy_w(prog_busy_w),
    .prog_susp_w(prog_susp_w), .erase_susp_w(erase_susp_w),
    .prog_cnt_w(prog_cnt_w), .erase_cnt_w(erase_cnt_w)
);

// File: tb/flash_op_arbiter_tb_top.sv
module flash_op_arbiter_tb_top;
    localparam int P = 8;
    localparam int E = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        param_top = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [23:0] cmd_addr = '0;
    logic        rd_valid_o, rd_ok_o;
    logic [4:0]  status_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    flash_op_arbiter #(.PROG_CYCLES(P), .ERASE_CYCLES(E)) dut_i (
        .clk(clk), .rst_n(rst_n), .param_top(param_top),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .rd_valid_o(rd_valid_o), .rd_ok_o(rd_ok_o), .status_o(status_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input int a);
        @(negedge clk);
        cmd_op   = op;
        cmd_addr = a[23:0];
        @(negedge clk);
        cmd_op   = 3'd0;
    endtask

    task automatic read_chk(input string tag, input int a, input int exp);
        cmd(3'd1, a);
        check({tag, " valid"}, int'(rd_valid_o), 1);
        check(tag, int'(rd_ok_o), exp);
    endtask

    task automatic wait_ready(output int at);
        int g = 0;
        while (!status_o[0] && g < 5000) begin
            @(negedge clk);
            g++;
        end
        at = cyc;
    endtask

    function automatic int blk_base(input int a, input int pt);
        int bank = a >>> 20;
        int off  = a & 32'hFFFFF;
        int pb   = pt ? 15 : 0;
        int sz   = ((bank == pb) && ((off >>> 16) == (pt ? 15 : 0))) ? 16384 : 65536;
        return a - (a % sz);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int k, s, r, at, t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset status", int'(status_o), 1);
        check("R1 reset rd_valid", int'(rd_valid_o), 0);

        // R2 program timing
        cmd(3'd2, 32'h123456); k = cyc;
        check("R2 busy after accept", int'(status_o), 0);
        repeat (P-1) @(negedge clk);
        check("R2 still busy at k+P-1", int'(status_o[0]), 0);
        @(negedge clk);
        check("R2 ready at k+P", int'(status_o), 1);

        // R3 erase timing
        cmd(3'd3, 32'h4A0000); k = cyc;
        check("R3 busy after accept", int'(status_o), 0);
        repeat (E-1) @(negedge clk);
        check("R3 still busy at k+E-1", int'(status_o[0]), 0);
        @(negedge clk);
        check("R3 ready at k+E", int'(status_o), 1);

        // R4 rejection while busy, R11 stickiness
        cmd(3'd3, 32'h300000); k = cyc;
        cmd(3'd2, 32'h900000);
        check("R4 program refused", int'(status_o), 5'b00010);
        cmd(3'd3, 32'h900000);
        check("R4 erase refused", int'(status_o), 5'b00110);
        wait_ready(at);
        check("R4 finish edge unchanged", at, k + E);
        repeat (4) @(negedge clk);
        check("R11 errors sticky", int'(status_o), 5'b00111);
        cmd(3'd6, 0);
        check("R11 clear", int'(status_o), 1);

        // R5 sweep: erase in a bank, read every bank
        for (int pt = 0; pt < 2; pt++) begin
            param_top = pt[0];
            for (int b = 0; b < 16; b += 5) begin
                cmd(3'd3, (b << 20) | 32'h1234);
                for (int rb = 0; rb < 16; rb++)
                    read_chk("R5 bank read", (rb << 20) | 32'h777, int'(rb != b));
                wait_ready(at);
            end
        end
        param_top = 1'b0;

        // R6 erase suspend, R7 program during it
        cmd(3'd3, 32'h230000); k = cyc;
        cmd(3'd4, 0); s = cyc;
        check("R6 erase suspended", int'(status_o), 5'b10001);
        read_chk("R6 read in erasing block", 32'h230005, 0);
        read_chk("R6 read same bank other block", 32'h240000, 1);
        read_chk("R6 read other bank", 32'h530000, 1);
        cmd(3'd2, 32'h231000);
        check("R7 program in erasing block refused", int'(status_o), 5'b10011);
        cmd(3'd6, 0);
        cmd(3'd2, 32'h270010); t = cyc;
        check("R7 program accepted", int'(status_o), 5'b10000);
        cmd(3'd4, 0);
        check("R7 nested suspend ignored", int'(status_o), 5'b10000);
        cmd(3'd5, 0);
        check("R7 nested resume ignored", int'(status_o), 5'b10000);
        wait_ready(at);
        check("R7 nested program finish", at, t + P);
        check("R7 erase still suspended", int'(status_o), 5'b10001);
        cmd(3'd5, 0); r = cyc;
        check("R9 erase resumed", int'(status_o), 0);
        wait_ready(at);
        check("R9 erase finish shifted", at, k + E + (r - s));

        // R8 program suspend, R9 frozen count
        cmd(3'd2, 32'h900100); k = cyc;
        cmd(3'd4, 0); s = cyc;
        check("R8 program suspended", int'(status_o), 5'b01001);
        read_chk("R8 read programmed word", 32'h900100, 0);
        read_chk("R8 read next word", 32'h900101, 1);
        read_chk("R8 read previous word", 32'h9000FF, 1);
        read_chk("R8 read other bank", 32'h100000, 1);
        repeat (5) @(negedge clk);
        cmd(3'd5, 0); r = cyc;
        check("R9 program resumed", int'(status_o), 0);
        wait_ready(at);
        check("R9 program finish shifted", at, k + P + (r - s));

        // R10 idle suspend/resume
        cmd(3'd4, 0);
        check("R10 idle suspend", int'(status_o), 1);
        cmd(3'd5, 0);
        check("R10 idle resume", int'(status_o), 1);
        read_chk("R10 idle read", 32'h000000, 1);

        // R12 block layout sweep
        for (int pt = 0; pt < 2; pt++) begin
            int pb;
            int tg [3];
            param_top = pt[0];
            pb = pt ? 15 : 0;
            tg[0] = (pb << 20) | (pt ? 32'hF0000 : 32'h0) | (1 << 14);
            tg[1] = (pb << 20) | 32'h80000;
            tg[2] = (7 << 20) | 32'h30000;
            for (int i = 0; i < 3; i++) begin
                cmd(3'd3, tg[i]);
                cmd(3'd4, 0);
                for (int g = 0; g < 64; g++) begin
                    int a = (tg[i] & 32'hF00000) | (g << 14) | 3;
                    read_chk("R12 block fence", a,
                             int'(blk_base(a, pt) != blk_base(tg[i], pt)));
                end
                cmd(3'd5, 0);
                wait_ready(at);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule